// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which interrupt a 16550-style UART raises and reports it to the host through an 8-bit read-only identification register and one interrupt line. It collects four candidate sources: receiver line errors, received data waiting, a receive character time-out, and an empty transmit holding register. Each source is gated by its own enable and then ranked. The register carries a 4-bit code for the winner. Its bit 0 is low whenever something is pending.

Every source is cleared by the host access that services it. A line-status read clears an error. The receive-data condition follows the FIFO level, so it drops when the buffer is drained. A receive-buffer read clears a time-out. A transmit write clears the transmit-empty source, and so does an identification read that actually returned the transmit-empty code. The time-out detector lives here and counts per-character-time ticks supplied by the baud logic. The FIFOs, shifters and bus decoding are outside the block and give it counts and strobes.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and on the first cycle after it (with FIFO mode off and no source active), the register reads 0x01 and the interrupt output is low.
- R2: With no enabled source pending, the code field (bits 3:0) is 0001. The interrupt output is high exactly when bit 0 of the register is 0.
- R3: Any nonzero receiver error flag makes the code 0110 from the next cycle on. This code outranks every other source. A line-status read with no new error clears it on the following cycle.
- R4: Received-data-available shows code 0100 in the same cycle its condition holds. In FIFO mode the condition is a count at or above a nonzero trigger level. With FIFO mode off it is any nonzero count.
- R5: In FIFO mode with a nonzero count, the time-out source shows code 1100. It becomes pending on the clock edge of the fourth character-time tick seen with no push or pop, and a receive-buffer read clears it.
- R6: A push or pop of the receive FIFO restarts the character-time count from zero.
- R7: When received-data-available and time-out are both pending, code 0100 is reported.
- R8: A rising edge of the transmit-empty status makes code 0010 pending. A transmit write clears it. An identification read also clears it, but only when the register shows 0010 in that cycle; a read showing any other code leaves it pending.
- R9: A source whose enable is low is never reported. Its pending state is kept and appears once the enable is raised.
- R10: Bits 7 and 6 both equal the FIFO-enable input, and bits 5 and 4 read 0.
- R11: With FIFO mode off, no time-out is ever raised and bit 3 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO mode setting |
| en_line | input | 1 | Enable for line-status source |
| en_rxdata | input | 1 | Enable for received-data and time-out sources |
| en_thre | input | 1 | Enable for transmit-empty source |
| err_flags | input | 4 | Overrun, parity, framing, break flags (any bit) |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Programmed receive trigger level |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register empty status |
| rd_lsr | input | 1 | Host read of line status register |
| rd_rbr | input | 1 | Host read of receive buffer |
| rd_iir | input | 1 | Host read of identification register |
| wr_thr | input | 1 | Host write of transmit holding register |
| iir | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with a FIFO depth of 16 and a time-out window of 4 character times. The depth gives a 5-bit count, so trigger levels up to 14 and a full FIFO of 16 can be driven. The short window lets the bench reach a time-out, make it pending, and break a count part way through with a push, all within a few dozen cycles. A behavioural model is compared with the register and interrupt output every cycle, and this covers the sequences where sources overlap, are masked, or are cleared by accesses in the same cycle.

// File: rtl/uirq_pkg.sv
// Shared definitions for the UART interrupt identification block.
// Assumes: the code field is 4 bits wide and bit 0 of it is active low.
package uirq_pkg;

    typedef enum logic [3:0] {
        ID_NONE    = 4'b0001,
        ID_LINE    = 4'b0110,
        ID_RXDATA  = 4'b0100,
        ID_TIMEOUT = 4'b1100,
        ID_THRE    = 4'b0010
    } iid_e;

endpackage

// File: rtl/uirq_timeout.sv
// Character time-out detector.
// Counts character-time ticks while FIFO mode is on and the receive FIFO
// holds data. Any push or pop restarts the count. The pending flag is raised
// on the tick that completes TO_CHARS quiet character times. It is cleared by
// a receive-buffer read or by leaving FIFO mode.
// Assumes: char_tick is a single-cycle pulse; strobes are single-cycle.
module uirq_timeout #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    input  logic rx_nonempty,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic char_tick,
    input  logic rd_rbr,
    output logic to_pend
);
    localparam int TW = $clog2(TO_CHARS + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TO_CHARS);
    localparam logic [TW-1:0] LAST  = TW'(TO_CHARS - 1);

    logic [TW-1:0] quiet_cnt;
    logic          hold_zero;
    logic          fire;

    // Decide whether the window restarts and whether this tick completes it.
    always_comb begin
        hold_zero = !fifo_en || !rx_nonempty || rx_push || rx_pop;
        fire      = !hold_zero && char_tick && (quiet_cnt == LAST);
    end

    // Quiet-time counter: restarts on activity, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_cnt <= '0;
        else if (hold_zero)
            quiet_cnt <= '0;
        else if (char_tick && quiet_cnt != LIMIT)
            quiet_cnt <= quiet_cnt + 1'b1;
    end

    // Pending flag: set by a completed window, cleared by a buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            to_pend <= 1'b0;
        else if (fire)
            to_pend <= 1'b1;
        else if (rd_rbr || !fifo_en)
            to_pend <= 1'b0;
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_cnt <= LIMIT);

    assert_to_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_pend) |-> $past(fifo_en && rx_nonempty && char_tick));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> quiet_cnt == '0);

    assert_no_to_nonfifo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> !to_pend);

endmodule

// File: rtl/uirq_pending.sv
// Pending flags for the line-status and transmit-empty sources.
// Line status is set by any error flag and cleared by a status read.
// Transmit-empty is set on the rising edge of the empty status and cleared
// by a transmit write or by an acknowledged identification read.
// In both flags a new set wins over a clear in the same cycle.
// Assumes: thre_ack is already qualified by the currently shown code.
module uirq_pending #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_flags,
    input  logic             rd_lsr,
    input  logic             thr_empty,
    input  logic             wr_thr,
    input  logic             thre_ack,
    output logic             ls_pend,
    output logic             thre_pend
);
    logic thr_q;
    logic thr_rise;

    // Edge detect on the transmit-empty status.
    always_comb thr_rise = thr_empty && !thr_q;

    // Delayed copy of the empty status; resets high so reset is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= 1'b1;
        else
            thr_q <= thr_empty;
    end

    // Line-status pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ls_pend <= 1'b0;
        else if (|err_flags)
            ls_pend <= 1'b1;
        else if (rd_lsr)
            ls_pend <= 1'b0;
    end

    // Transmit-empty pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thre_pend <= 1'b0;
        else if (thr_rise)
            thre_pend <= 1'b1;
        else if (wr_thr || thre_ack)
            thre_pend <= 1'b0;
    end

    assert_ls_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_flags) |=> ls_pend);

    assert_ls_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !(|err_flags)) |=> !ls_pend);

    assert_thre_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !thr_rise) |=> !thre_pend);

    assert_thre_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_rise |=> thre_pend);

endmodule

// File: rtl/uirq_prio.sv
// Fixed-priority selector for the masked interrupt sources.
// Ranking: line status, then received data, then time-out, then
// transmit-empty. When nothing is active the code is ID_NONE.
// Assumes: inputs are already masked by their enables.
module uirq_prio
    import uirq_pkg::*;
(
    input  logic ls_act,
    input  logic rda_act,
    input  logic to_act,
    input  logic thre_act,
    output iid_e code
);
    // Pick the highest-ranked active source.
    always_comb begin
        if (ls_act)
            code = ID_LINE;
        else if (rda_act)
            code = ID_RXDATA;
        else if (to_act)
            code = ID_TIMEOUT;
        else if (thre_act)
            code = ID_THRE;
        else
            code = ID_NONE;
    end

endmodule

// File: rtl/uart_irq_ident.sv
// UART interrupt identification top.
// Masks each source with its enable, ranks the sources, and forms the
// 8-bit identification value {fifo_en, fifo_en, 2'b00, code}. The
// interrupt output is active when code bit 0 is low. Received-data-available
// is a level taken from the FIFO count, so it drops as soon as the buffer
// read lowers the count.
// Assumes: rx_trig is nonzero in FIFO mode; all strobes are one cycle.
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter  int FIFO_DEPTH = 16,
    parameter  int TO_CHARS   = 4,
    parameter  int ERR_W      = 4,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             en_line,
    input  logic             en_rxdata,
    input  logic             en_thre,
    input  logic [ERR_W-1:0] err_flags,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    input  logic             thr_empty,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             rd_iir,
    input  logic             wr_thr,
    output logic [7:0]       iir,
    output logic             irq
);
    logic rx_nonempty;
    logic rda_raw;
    logic ls_pend;
    logic thre_pend;
    logic to_pend;
    logic thre_ack;
    iid_e code;

    // Received-data condition from the FIFO level and mode.
    always_comb begin
        rx_nonempty = (rx_count != '0);
        rda_raw     = fifo_en ? (rx_nonempty && rx_count >= rx_trig) : rx_nonempty;
    end

    uirq_timeout #(
        .TO_CHARS (TO_CHARS)
    ) u_timeout (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (fifo_en),
        .rx_nonempty (rx_nonempty),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .char_tick   (char_tick),
        .rd_rbr      (rd_rbr),
        .to_pend     (to_pend)
    );

    uirq_pending #(
        .ERR_W (ERR_W)
    ) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_flags (err_flags),
        .rd_lsr    (rd_lsr),
        .thr_empty (thr_empty),
        .wr_thr    (wr_thr),
        .thre_ack  (thre_ack),
        .ls_pend   (ls_pend),
        .thre_pend (thre_pend)
    );

    uirq_prio u_prio (
        .ls_act   (ls_pend   && en_line),
        .rda_act  (rda_raw   && en_rxdata),
        .to_act   (to_pend   && en_rxdata),
        .thre_act (thre_pend && en_thre),
        .code     (code)
    );

    // Assemble the register, the interrupt line, and the read acknowledge.
    always_comb begin
        iir      = {fifo_en, fifo_en, 2'b00, code};
        irq      = !code[0];
        thre_ack = rd_iir && (code == ID_THRE);
    end

    assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && en_line) |-> iir[3:0] == ID_LINE);

    assert_bit3_fifo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        iir[3] |-> (fifo_en && iir[2]));

    assert_mask_thre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_thre |-> iir[3:0] != ID_THRE);

    assert_rda_over_to_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rda_raw && en_rxdata && !(ls_pend && en_line)) |-> iir[3:0] == ID_RXDATA);

endmodule

// File: tb/uart_irq_ident_bench.sv
// Self-checking bench: a behavioural reference model is updated at each
// rising edge and compared with the outputs in the middle of each low phase.
module uart_irq_ident_bench;
    localparam int DEPTH = 16;
    localparam int TOC   = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b0, en_line = 1'b0, en_rxdata = 1'b0, en_thre = 1'b0;
    logic [3:0]    err_flags = '0;
    logic [CW-1:0] rx_count = '0, rx_trig = CW'(1);
    logic          rx_push = 0, rx_pop = 0, char_tick = 0, thr_empty = 1;
    logic          rd_lsr = 0, rd_rbr = 0, rd_iir = 0, wr_thr = 0;
    logic [7:0]    iir;
    logic          irq;

    int checks = 0, failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_ls = 0, m_to = 0, m_thre = 0, m_thr_q = 1, m_cnt = 0;

    always #5 clk = ~clk;

    uart_irq_ident #(.FIFO_DEPTH(DEPTH), .TO_CHARS(TOC)) u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .en_line(en_line),
        .en_rxdata(en_rxdata), .en_thre(en_thre), .err_flags(err_flags),
        .rx_count(rx_count), .rx_trig(rx_trig), .rx_push(rx_push),
        .rx_pop(rx_pop), .char_tick(char_tick), .thr_empty(thr_empty),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir), .wr_thr(wr_thr),
        .iir(iir), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] model_id();
        int rda;
        if (!rst_n) return 4'b0001;
        if (fifo_en) rda = (rx_count != 0) && (int'(rx_count) >= int'(rx_trig));
        else         rda = (rx_count != 0);
        if (m_ls != 0 && en_line)     return 4'b0110;
        if (rda != 0 && en_rxdata)    return 4'b0100;
        if (m_to != 0 && en_rxdata)   return 4'b1100;
        if (m_thre != 0 && en_thre)   return 4'b0010;
        return 4'b0001;
    endfunction

    // One clock: compare, advance model at the edge, then drop strobes.
    task automatic cyc();
        logic [3:0] id;
        string tag;
        int rise, quiet;
        #1;
        id = model_id();
        case (id)
            4'b0110: tag = "R3 line code";
            4'b0100: tag = "R4 rxdata code";
            4'b1100: tag = "R5 timeout code";
            4'b0010: tag = "R8 thre code";
            default: tag = "R2 idle code";
        endcase
        chk(tag, {4'b0000, iir[3:0]}, {4'b0000, id});
        chk("R10 upper bits", {iir[7:4], 4'b0000}, {fifo_en, fifo_en, 2'b00, 4'b0000});
        chk("R2 irq line", {7'b0, irq}, {7'b0, ~id[0]});
        @(posedge clk);
        if (!rst_n) begin
            m_ls = 0; m_to = 0; m_thre = 0; m_thr_q = 1; m_cnt = 0;
        end else begin
            rise = (thr_empty && m_thr_q == 0);
            if (rise != 0) m_thre = 1;
            else if (wr_thr || (rd_iir && id == 4'b0010)) m_thre = 0;
            m_thr_q = thr_empty;
            if (err_flags != 0) m_ls = 1;
            else if (rd_lsr) m_ls = 0;
            quiet = fifo_en && rx_count != 0 && !rx_push && !rx_pop;
            if (quiet != 0 && char_tick && m_cnt == TOC - 1) m_to = 1;
            else if (rd_rbr || !fifo_en) m_to = 0;
            if (quiet == 0) m_cnt = 0;
            else if (char_tick && m_cnt < TOC) m_cnt++;
        end
        @(negedge clk);
        err_flags = '0; rx_push = 0; rx_pop = 0; char_tick = 0;
        rd_lsr = 0; rd_rbr = 0; rd_iir = 0; wr_thr = 0;
    endtask

    task automatic expect_iir(input string tag, input logic [7:0] v);
        #1;
        chk(tag, iir, v);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc();
        expect_iir("R1 reset value", 8'h01);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1;
        cyc();
        expect_iir("R1 after reset", 8'h01);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        en_line = 1; en_rxdata = 1; en_thre = 1;

        // R8: edge sets, acknowledged read clears
        thr_empty = 0; cyc(); thr_empty = 1; cyc();
        expect_iir("R8 thre pending", 8'h02);
        chk("R2 irq high", {7'b0, irq}, 8'h01);
        rd_iir = 1; cyc();
        expect_iir("R8 cleared by id read", 8'h01);
        // R8: transmit write clears
        thr_empty = 0; cyc(); thr_empty = 1; cyc();
        wr_thr = 1; cyc();
        expect_iir("R8 cleared by write", 8'h01);

        // R4 / R11: non-FIFO data, ticks do not raise a time-out
        rx_count = 1; rx_push = 1;
        expect_iir("R4 non-fifo data", 8'h04);
        cyc();
        for (int i = 0; i < 6; i++) begin char_tick = 1; cyc(); end
        rd_rbr = 1; rx_pop = 1; rx_count = 0;
        expect_iir("R11 no timeout non-fifo", 8'h01);
        cyc();
        expect_iir("R11 still idle", 8'h01);

        // R3: error outranks data; status read clears
        rx_count = 1; err_flags = 4'b0010; cyc();
        expect_iir("R3 line first", 8'h06);
        rd_lsr = 1; cyc();
        expect_iir("R3 cleared", 8'h04);
        rx_count = 0; cyc();

        // R10 / R5: FIFO mode time-out
        fifo_en = 1; rx_trig = CW'(4); rx_count = 3; rx_push = 1;
        expect_iir("R10 fifo bits", 8'hC1);
        cyc();
        for (int i = 0; i < TOC - 1; i++) begin char_tick = 1; cyc(); end
        expect_iir("R5 not yet", 8'hC1);
        char_tick = 1; cyc();
        expect_iir("R5 timeout", 8'hCC);
        // R7: data condition outranks time-out
        rx_count = 4;
        expect_iir("R7 data over timeout", 8'hC4);
        cyc();
        rd_rbr = 1; rx_pop = 1; rx_count = 3; cyc();
        expect_iir("R5 cleared by read", 8'hC1);

        // R6: push in the middle restarts the window
        for (int i = 0; i < TOC - 1; i++) begin char_tick = 1; cyc(); end
        rx_push = 1; rx_count = 3; cyc();
        for (int i = 0; i < TOC - 1; i++) begin char_tick = 1; cyc(); end
        expect_iir("R6 restarted", 8'hC1);
        char_tick = 1; cyc();
        expect_iir("R6 fires after full window", 8'hCC);
        rd_rbr = 1; rx_pop = 1; rx_count = 0; cyc();

        // R9: masked sources keep pending state
        en_line = 0; en_thre = 0;
        err_flags = 4'b1000; thr_empty = 0; cyc(); thr_empty = 1; cyc();
        expect_iir("R9 both masked", 8'hC1);
        rd_iir = 1; cyc();
        en_thre = 1;
        expect_iir("R9 thre kept", 8'hC2);
        en_line = 1;
        expect_iir("R9 line kept", 8'hC6);
        // R8: id read showing another code leaves transmit-empty pending
        rd_iir = 1; cyc();
        rd_lsr = 1; cyc();
        expect_iir("R8 survives other read", 8'hC2);
        rd_iir = 1; cyc();
        expect_iir("R8 acked", 8'hC1);

        fifo_en = 0; cyc(); cyc();
        expect_iir("R10 fifo off", 8'h01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule